// File: doc/BRIEF.md
# I2C Register Port with Packet Error Check

This block is an I2C target that gives a host access to a small register file. Each transaction carries a trailing CRC-8 check byte. A write frame has four bytes: the target address, a register pointer, one data byte and the check byte. The block buffers the data byte. It drives the register write strobe only when the received check byte equals the CRC it has accumulated. On a mismatch the check byte is NACKed and the data is dropped without any other sign.

A read uses the usual combined format. The host writes the target address and the register pointer. It then issues a repeated START and the target address with the read bit set. The target returns the addressed register and, if the host ACKs it, a check byte. The CRC restarts from zero at every START and every repeated START. The system clock samples SCL and SDA through synchronisers, and the block only ever drives SDA low through an open-drain enable.

Top module: `i2c_pec_regport`

## Requirements
- R1: The target responds to the 7-bit address whose upper three bits are 101 and whose lower four bits equal `addr_sel_i` (address byte = {3'b101, addr_sel_i, rw}, rw=0 write, rw=1 read). Any other address is NACKed, and every later byte is NACKed until the next START.
- R2: In a write frame the target ACKs the address byte, the register pointer byte and the data byte, each in the 9th clock slot.
- R3: The check value is a CRC-8 with polynomial 0x07. It starts at 0 on every START and repeated START and is updated bytewise: XOR the byte in, then eight steps, each a left shift followed by XOR with 0x07 when the bit shifted out was 1. It covers the address byte, so a check byte computed without the address byte is rejected.
- R4: When the check byte matches the CRC over address, pointer and data, the target ACKs it and drives `reg_we_o` for exactly one cycle, with `reg_addr_o` equal to the low bits of the pointer and `reg_wdata_o` equal to the data byte.
- R5: When the check byte does not match, the target leaves SDA released in its 9th clock and no register write occurs.
- R6: A STOP or repeated START that arrives before the check byte completes leaves every register unchanged.
- R7: After a repeated START with the read bit set, the target sends the register selected by the last pointer, MSB first.
- R8: If the host ACKs the data byte, the target then sends a check byte. This byte is the CRC over the read address byte and the data byte, starting from 0 at the repeated START.
- R9: After reset SDA is released and `reg_we_o` is low.
- R10: The target never changes its SDA drive while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain enable) |
| addr_sel_i | input | 4 | Low four bits of the target address |
| reg_addr_o | output | REG_AW | Register pointer used for reads and writes |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Data for the register write |
| reg_rdata_i | input | 8 | Contents of the register at reg_addr_o |

## Verification
The assertions check on every cycle that SDA drive never changes while SCL is high and that the bus is released while the target is idle or ignoring the bus. They also check that a write strobe lasts one cycle and appears only in the slot of an accepted check byte, and that the CRC clears after each START. Only the bench scenarios can show the rest. These are: which frames are ACKed or NACKed, whether a check byte that skips the address is rejected, whether an aborted or corrupted write leaves the register intact (shown by reading it back), and whether the returned data and check byte carry the right values.

// File: rtl/i2c_pec_pkg.sv
package i2c_pec_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_SUB, ST_SACK, ST_DATA, ST_DACK,
    ST_PEC, ST_PACK, ST_TX, ST_TACK, ST_HOLD
  } tgt_state_e;

  function automatic logic [7:0] crc8_byte(input logic [7:0] c,
                                           input logic [7:0] b,
                                           input logic [7:0] poly);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ({r[6:0], 1'b0} ^ poly) : {r[6:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // bus idles high, so reset to 1 to avoid a fake edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2c_crc8_acc.sv
module i2c_crc8_acc #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic [7:0] byte_i,
  output logic [7:0] crc_o
);
  import i2c_pec_pkg::*;

  logic [7:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= 8'h00;
    else if (clr_i)  crc_q <= 8'h00;
    else if (upd_i)  crc_q <= crc8_byte(crc_q, byte_i, POLY);
  end

  assign crc_o = crc_q;

  AST_CRC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_o == 8'h00)); // R3

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm #(
  parameter logic [2:0] ADDR_PREFIX = 3'b101,
  parameter int         REG_AW      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic [3:0]        addr_sel_i,
  input  logic [7:0]        crc_i,
  output logic              crc_clr_o,
  output logic              crc_upd_o,
  output logic [7:0]        crc_byte_o,
  input  logic [7:0]        reg_rdata_i,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [7:0]        reg_wdata_o,
  output logic              sda_oe_o
);
  import i2c_pec_pkg::*;

  tgt_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        rx_sh_q, tx_sh_q, dbuf_q;
  logic [REG_AW-1:0] ptr_q;
  logic              ack_q, ack_phase_q, rd_q, pec_sent_q, mack_q, we_q, sda_oe_q;

  logic       start_evt, stop_evt, rx_state, rx_done, load_data, addr_hit;
  logic [7:0] rx_byte;

  always_comb begin
    start_evt = sda_fall_i & scl_lvl_i;
    stop_evt  = sda_rise_i & scl_lvl_i;
    rx_state  = (state_q == ST_ADDR) || (state_q == ST_SUB) ||
                (state_q == ST_DATA) || (state_q == ST_PEC);
    rx_byte   = {rx_sh_q[6:0], sda_lvl_i};
    rx_done   = rx_state & scl_rise_i & (bit_cnt_q == 4'd7);
    addr_hit  = (rx_byte[7:1] == {ADDR_PREFIX, addr_sel_i});
    load_data = (state_q == ST_AACK) & ack_phase_q & scl_fall_i & rd_q;
    crc_clr_o  = start_evt;
    crc_upd_o  = (rx_done & (state_q != ST_PEC)) | load_data;
    crc_byte_o = load_data ? reg_rdata_i : rx_byte;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      dbuf_q      <= '0;
      ptr_q       <= '0;
      ack_q       <= 1'b0;
      ack_phase_q <= 1'b0;
      rd_q        <= 1'b0;
      pec_sent_q  <= 1'b0;
      mack_q      <= 1'b0;
      we_q        <= 1'b0;
      sda_oe_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_evt) begin
        state_q     <= ST_ADDR;
        bit_cnt_q   <= '0;
        sda_oe_q    <= 1'b0;
        ack_phase_q <= 1'b0;
        pec_sent_q  <= 1'b0;
      end else if (stop_evt) begin
        state_q     <= ST_IDLE;
        sda_oe_q    <= 1'b0;
        ack_phase_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_SUB, ST_DATA, ST_PEC: begin
            if (scl_rise_i) begin
              rx_sh_q   <= rx_byte;
              bit_cnt_q <= bit_cnt_q + 4'd1;
              if (bit_cnt_q == 4'd7) begin
                bit_cnt_q <= '0;
                ack_q     <= 1'b1;
                case (state_q)
                  ST_ADDR: begin
                    rd_q    <= rx_byte[0];
                    state_q <= addr_hit ? ST_AACK : ST_HOLD;
                  end
                  ST_SUB: begin
                    ptr_q   <= rx_byte[REG_AW-1:0];
                    state_q <= ST_SACK;
                  end
                  ST_DATA: begin
                    dbuf_q  <= rx_byte;
                    state_q <= ST_DACK;
                  end
                  default: begin
                    ack_q   <= (rx_byte == crc_i);
                    we_q    <= (rx_byte == crc_i);
                    state_q <= ST_PACK;
                  end
                endcase
              end
            end
          end
          ST_AACK, ST_SACK, ST_DACK, ST_PACK: begin
            if (scl_fall_i) begin
              if (!ack_phase_q) begin
                sda_oe_q    <= ack_q;
                ack_phase_q <= 1'b1;
              end else begin
                ack_phase_q <= 1'b0;
                sda_oe_q    <= 1'b0;
                case (state_q)
                  ST_AACK: begin
                    if (rd_q) begin
                      tx_sh_q   <= reg_rdata_i;
                      sda_oe_q  <= ~reg_rdata_i[7];
                      bit_cnt_q <= '0;
                      state_q   <= ST_TX;
                    end else begin
                      state_q <= ST_SUB;
                    end
                  end
                  ST_SACK: state_q <= ST_DATA;
                  ST_DACK: state_q <= ST_PEC;
                  default: state_q <= ST_HOLD;
                endcase
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (bit_cnt_q == 4'd8) begin
                sda_oe_q  <= 1'b0;
                bit_cnt_q <= '0;
                state_q   <= ST_TACK;
              end else begin
                tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
                sda_oe_q <= ~tx_sh_q[6];
              end
            end
          end
          ST_TACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_lvl_i;
            end else if (scl_fall_i) begin
              if (mack_q && !pec_sent_q) begin
                tx_sh_q    <= crc_i;
                sda_oe_q   <= ~crc_i[7];
                pec_sent_q <= 1'b1;
                state_q    <= ST_TX;
              end else begin
                state_q <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_addr_o  = ptr_q;
  assign reg_we_o    = we_q;
  assign reg_wdata_o = dbuf_q;
  assign sda_oe_o    = sda_oe_q;

  AST_WE_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q); // R4
  AST_WE_IN_PEC_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (state_q == ST_PACK) && ack_q); // R4
  AST_BAD_PEC_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && state_q == ST_PEC && rx_byte != crc_i) |=> !we_q); // R5
  AST_IGNORE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD || state_q == ST_IDLE) |-> !sda_oe_q); // R1
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_lvl_i && $past(scl_lvl_i)) |-> $stable(sda_oe_q)); // R10

endmodule

// File: rtl/i2c_pec_regport.sv
module i2c_pec_regport #(
  parameter logic [2:0] ADDR_PREFIX = 3'b101,
  parameter int         REG_AW      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CRC_POLY    = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [3:0]        addr_sel_i,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [7:0]        reg_wdata_o,
  input  logic [7:0]        reg_rdata_i
);
  localparam int NLINES = 2; // 0: SCL, 1: SDA

  logic [NLINES-1:0] raw, lvl, rise, fall;
  logic              crc_clr, crc_upd;
  logic [7:0]        crc_byte, crc_val;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .level_o(lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  i2c_crc8_acc #(.POLY(CRC_POLY)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (crc_clr),
    .upd_i (crc_upd),
    .byte_i(crc_byte),
    .crc_o (crc_val)
  );

  i2c_target_fsm #(.ADDR_PREFIX(ADDR_PREFIX), .REG_AW(REG_AW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (lvl[0]),
    .scl_rise_i (rise[0]),
    .scl_fall_i (fall[0]),
    .sda_lvl_i  (lvl[1]),
    .sda_rise_i (rise[1]),
    .sda_fall_i (fall[1]),
    .addr_sel_i (addr_sel_i),
    .crc_i      (crc_val),
    .crc_clr_o  (crc_clr),
    .crc_upd_o  (crc_upd),
    .crc_byte_o (crc_byte),
    .reg_rdata_i(reg_rdata_i),
    .reg_addr_o (reg_addr_o),
    .reg_we_o   (reg_we_o),
    .reg_wdata_o(reg_wdata_o),
    .sda_oe_o   (sda_oe_o)
  );

endmodule

// File: tb/i2c_pec_regport_tb_top.sv
`timescale 1ns/1ps
module i2c_pec_regport_tb_top;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl = 1'b1;
  logic          sda_m = 1'b1;
  logic          sda_oe;
  logic [3:0]    sel = 4'hA;
  logic [AW-1:0] raddr;
  logic          we;
  logic [7:0]    wdata;
  logic [7:0]    regs [16];
  logic          sda_line;

  int n_chk = 0;
  int n_fail = 0;
  logic [11:0] exp_q [$];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_pec_regport dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_sel_i(sel), .reg_addr_o(raddr),
    .reg_we_o(we), .reg_wdata_o(wdata), .reg_rdata_i(regs[raddr])
  );

  always_ff @(posedge clk) if (we) regs[raddr] <= wdata;

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R6 unexpected write", {raddr, wdata}, 0);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        check({raddr, wdata} == e, "R4 write addr/data", {raddr, wdata}, e);
      end
    end
  end

  task automatic bit_out(input logic b);
    sda_m = b; #50; scl = 1'b1; #100; scl = 1'b0; #50;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; #50; scl = 1'b1; #50; b = sda_line; #50; scl = 1'b0; #50;
  endtask

  task automatic do_start;
    sda_m = 1'b0; #100; scl = 1'b0; #50;
  endtask

  task automatic do_rstart;
    sda_m = 1'b1; #50; scl = 1'b1; #100; sda_m = 1'b0; #100; scl = 1'b0; #50;
  endtask

  task automatic do_stop;
    sda_m = 1'b0; #50; scl = 1'b1; #100; sda_m = 1'b1; #300;
  endtask

  task automatic wbyte(input logic [7:0] d, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    acked = !b;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(!mack);
  endtask

  function automatic logic [7:0] aw(input logic [3:0] s); return {3'b101, s, 1'b0}; endfunction
  function automatic logic [7:0] ar(input logic [3:0] s); return {3'b101, s, 1'b1}; endfunction

  // full write; pec_mode 0: correct, 1: corrupted, 2: address byte left out
  task automatic wr_frame(input logic [3:0] s, input logic [7:0] sub, input logic [7:0] d,
                          input int pec_mode, output bit a0, output bit a1,
                          output bit a2, output bit a3);
    logic [7:0] p;
    p = bcrc(bcrc(bcrc(8'h00, aw(s)), sub), d);
    if (pec_mode == 1) p = p ^ 8'h01;
    if (pec_mode == 2) p = bcrc(bcrc(8'h00, sub), d);
    do_start;
    wbyte(aw(s), a0); wbyte(sub, a1); wbyte(d, a2); wbyte(p, a3);
    do_stop;
  endtask

  task automatic rd_frame(input logic [7:0] sub, output logic [7:0] d,
                          output logic [7:0] pec, output bit ok);
    bit a0, a1, a2;
    do_start;
    wbyte(aw(sel), a0); wbyte(sub, a1);
    do_rstart;
    wbyte(ar(sel), a2);
    rbyte(1'b1, d);
    rbyte(1'b0, pec);
    do_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic check_read(input logic [7:0] sub, input logic [7:0] exp, input string req);
    logic [7:0] d, p;
    bit ok;
    rd_frame(sub, d, p, ok);
    check(ok, "R7 read frame acks", ok, 1);
    check(d == exp, req, d, exp);
    check(p == bcrc(bcrc(8'h00, ar(sel)), exp), "R8 read PEC", p, bcrc(bcrc(8'h00, ar(sel)), exp));
  endtask

  initial begin
    #500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit a0, a1, a2, a3;
    for (int i = 0; i < 16; i++) regs[i] = 8'h00;
    #42; rst_n = 1'b1; #40;
    check(sda_oe == 1'b0, "R9 SDA released after reset", sda_oe, 0);
    check(we == 1'b0, "R9 no strobe after reset", we, 0);

    // valid writes
    exp_q.push_back({4'h3, 8'h5A});
    wr_frame(sel, 8'h03, 8'h5A, 0, a0, a1, a2, a3);
    check(a0, "R1 address ACK", a0, 1);
    check(a1 && a2, "R2 pointer/data ACK", {a1, a2}, 3);
    check(a3, "R4 valid PEC ACK", a3, 1);
    exp_q.push_back({4'h7, 8'hFF});
    wr_frame(sel, 8'h07, 8'hFF, 0, a0, a1, a2, a3);
    check(a3, "R4 valid PEC ACK ff", a3, 1);
    exp_q.push_back({4'h0, 8'h00});
    wr_frame(sel, 8'hF0, 8'h00, 0, a0, a1, a2, a3);
    check(a3, "R4 valid PEC ACK 00", a3, 1);

    // corrupted PEC
    wr_frame(sel, 8'h03, 8'h11, 1, a0, a1, a2, a3);
    check(!a3, "R5 bad PEC NACK", a3, 0);
    // PEC computed without the address byte
    wr_frame(sel, 8'h03, 8'h22, 2, a0, a1, a2, a3);
    check(!a3, "R3 PEC must cover address", a3, 0);
    // wrong address
    wr_frame(4'h5, 8'h03, 8'h33, 0, a0, a1, a2, a3);
    check(!a0, "R1 foreign address NACK", a0, 0);
    check(!a1 && !a2 && !a3, "R1 later bytes ignored", {a1, a2, a3}, 0);

    // abort by STOP after the data byte
    do_start; wbyte(aw(sel), a0); wbyte(8'h03, a1); wbyte(8'h44, a2); do_stop;
    check(a2, "R6 data ACK before abort", a2, 1);
    // abort by repeated START, then read register 7
    do_start; wbyte(aw(sel), a0); wbyte(8'h07, a1); wbyte(8'h55, a2);
    do_rstart; wbyte(ar(sel), a3);
    begin
      logic [7:0] d, p;
      rbyte(1'b1, d); rbyte(1'b0, p); do_stop;
      check(d == 8'hFF, "R6 register intact after restart abort", d, 8'hFF);
      check(p == bcrc(bcrc(8'h00, ar(sel)), 8'hFF), "R3 CRC restarts at repeated START", p,
            bcrc(bcrc(8'h00, ar(sel)), 8'hFF));
    end

    check_read(8'h03, 8'h5A, "R5/R6 reg3 intact, R7 read data");
    check_read(8'h00, 8'h00, "R7 read reg0");

    // new address select
    sel = 4'h3;
    exp_q.push_back({4'h9, 8'hC3});
    wr_frame(sel, 8'h09, 8'hC3, 0, a0, a1, a2, a3);
    check(a0 && a3, "R1 new address select", {a0, a3}, 3);
    check_read(8'h09, 8'hC3, "R7 read reg9");

    #200;
    check(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule